// File: doc/BRIEF.md
# Sequential Signed 16x16 Multiplier

This block multiplies two 16-bit operands with one small unsigned byte multiplier that is reused over several clock cycles. A start strobe latches both operands and a mode bit. The controller then walks through four byte-wise partial products: low by low, high by high, and the two cross terms. The first two are written straight into their halves of a 32-bit result register. The cross terms are added one byte up, with the carry rippling to the top.

In signed mode, two more cycles fix up the upper result word. If the second operand is negative, the first operand is subtracted from the upper 16 bits. If the first operand is negative, the second operand is then subtracted in the same way. This gives the two's-complement product modulo 2^32. In unsigned mode both fix-up cycles are skipped, and the result is the plain unsigned product.

The result is reported with a busy flag and a one-cycle done pulse. The product output holds its value until the next accepted start.

Top module: `seq_smul16`

## Requirements
- R1: With rst high at a clock edge, the block goes to busy=0, done=0, product=0 after that edge.
- R2: With unsigned_mode=0, product equals the two's-complement product of op_a and op_b, as a 32-bit two's-complement value, when done is high.
- R3: With unsigned_mode=1, product equals the unsigned 32-bit product of op_a and op_b when done is high.
- R4: done is high after the 6th rising edge following the edge that accepts start in signed mode, and after the 4th such edge in unsigned mode.
- R5: done is high for exactly one cycle per operation, and busy is low while done is high.
- R6: start is accepted only when busy is low. A start pulse while busy changes neither the result nor the done timing of the running operation.
- R7: op_a, op_b and unsigned_mode are captured at the accepting edge. Changes to them while busy do not affect the result.
- R8: After done, product keeps its value until the next start is accepted.
- R9: When both operands are negative, both corrections apply. For example, -32768 * -32768 gives 32'h4000_0000, and -1 * -1 gives 32'h0000_0001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| unsigned_mode | input | 1 | 1 = unsigned product, 0 = signed product |
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse, product valid |
| product | output | 32 | 32-bit result |

## Verification
The bench targets operands whose top bit is set, where the fix-up subtractions decide the answer. A design that skips or misorders a correction gives the unsigned product, or one off by an operand times 2^16. -32768 squared and -32768 times 1 expose a missing borrow into the top byte. Random pairs expose a cross-product carry that does not reach byte 3, which corrupts the upper word. Further scenarios drive a start pulse while busy and change the operands mid-operation. A design that restarts or samples its inputs live would show a wrong latency or a mixed-operand result.

// File: rtl/smul_pkg.sv
package smul_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_LL   = 3'd1,
    ST_HH   = 3'd2,
    ST_LH   = 3'd3,
    ST_HL   = 3'd4,
    ST_CB   = 3'd5,
    ST_CA   = 3'd6
  } step_t;
endpackage

// File: rtl/smul_bytemul.sv
module smul_bytemul #(
  parameter int W = 8
) (
  input  logic [W-1:0]   x,
  input  logic [W-1:0]   y,
  output logic [2*W-1:0] p
);
  localparam int PW = 2 * W;

  logic [PW-1:0] row [W];
  logic [PW-1:0] sum;

  // One shifted row per multiplier bit
  genvar gi;
  generate
    for (gi = 0; gi < W; gi++) begin : g_row
      assign row[gi] = y[gi] ? ({{W{1'b0}}, x} << gi) : '0;
    end
  endgenerate

  always_comb begin
    sum = '0;
    for (int k = 0; k < W; k++) sum = sum + row[k];
  end

  assign p = sum;
endmodule

// File: rtl/smul_seq.sv
module smul_seq
  import smul_pkg::*;
#(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic           umode,
  input  logic [2*W-1:0] a_in,
  input  logic [2*W-1:0] b_in,
  output logic           busy,
  output logic           done,
  output step_t          step,
  output logic [2*W-1:0] a_q,
  output logic [2*W-1:0] b_q,
  output logic [W-1:0]   mul_x,
  output logic [W-1:0]   mul_y
);
  localparam int OW = 2 * W;

  step_t state;
  logic  um_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      done  <= 1'b0;
      a_q   <= '0;
      b_q   <= '0;
      um_q  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          a_q   <= a_in;
          b_q   <= b_in;
          um_q  <= umode;
          state <= ST_LL;
        end
        ST_LL: state <= ST_HH;
        ST_HH: state <= ST_LH;
        ST_LH: state <= ST_HL;
        ST_HL: if (um_q) begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end else begin
          state <= ST_CB;
        end
        ST_CB: state <= ST_CA;
        ST_CA: begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);
  assign step = state;

  // Byte selection for the shared multiplier
  always_comb begin
    case (state)
      ST_HH:   begin mul_x = a_q[OW-1:W]; mul_y = b_q[OW-1:W]; end
      ST_LH:   begin mul_x = a_q[W-1:0];  mul_y = b_q[OW-1:W]; end
      ST_HL:   begin mul_x = a_q[OW-1:W]; mul_y = b_q[W-1:0];  end
      default: begin mul_x = a_q[W-1:0];  mul_y = b_q[W-1:0];  end
    endcase
  end

  a_r5_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r5_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  a_r7_operands_held: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(a_q) && $stable(b_q)));
  a_r3_skip_corr: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HL && um_q) |=> (done && !busy));
  a_r4_done_from_busy: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(busy));
endmodule

// File: rtl/smul_acc.sv
module smul_acc
  import smul_pkg::*;
#(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  step_t          step,
  input  logic [2*W-1:0] pp,
  input  logic [2*W-1:0] a_q,
  input  logic [2*W-1:0] b_q,
  output logic [4*W-1:0] product
);
  localparam int OW = 2 * W;
  localparam int RW = 4 * W;

  logic [RW-1:0] res_q;
  logic [RW-1:0] res_d;

  always_comb begin
    res_d = res_q;
    case (step)
      ST_LL: res_d[OW-1:0]  = pp;
      ST_HH: res_d[RW-1:OW] = pp;
      ST_LH, ST_HL: res_d = res_q + {{W{1'b0}}, pp, {W{1'b0}}};
      ST_CB: if (b_q[OW-1]) res_d[RW-1:OW] = res_q[RW-1:OW] - a_q;
      ST_CA: if (a_q[OW-1]) res_d[RW-1:OW] = res_q[RW-1:OW] - b_q;
      default: res_d = res_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) res_q <= '0;
    else     res_q <= res_d;
  end

  assign product = res_q;

  a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (step == ST_IDLE) |=> $stable(product));
  a_r2_no_corr_b: assert property (@(posedge clk) disable iff (rst)
    (step == ST_CB && !b_q[OW-1]) |=> $stable(product));
  a_r2_no_corr_a: assert property (@(posedge clk) disable iff (rst)
    (step == ST_CA && !a_q[OW-1]) |=> $stable(product));
  a_r2_low_kept_corr: assert property (@(posedge clk) disable iff (rst)
    (step == ST_CB || step == ST_CA) |=> $stable(product[OW-1:0]));
endmodule

// File: rtl/seq_smul16.sv
module seq_smul16
  import smul_pkg::*;
#(
  parameter int HALF_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                unsigned_mode,
  input  logic [2*HALF_W-1:0] op_a,
  input  logic [2*HALF_W-1:0] op_b,
  output logic                busy,
  output logic                done,
  output logic [4*HALF_W-1:0] product
);
  localparam int OW = 2 * HALF_W;

  step_t           step;
  logic [OW-1:0]   a_q;
  logic [OW-1:0]   b_q;
  logic [HALF_W-1:0] mul_x;
  logic [HALF_W-1:0] mul_y;
  logic [OW-1:0]   pp;

  smul_seq #(.W(HALF_W)) u_seq (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .umode (unsigned_mode),
    .a_in  (op_a),
    .b_in  (op_b),
    .busy  (busy),
    .done  (done),
    .step  (step),
    .a_q   (a_q),
    .b_q   (b_q),
    .mul_x (mul_x),
    .mul_y (mul_y)
  );

  smul_bytemul #(.W(HALF_W)) u_mul (
    .x (mul_x),
    .y (mul_y),
    .p (pp)
  );

  smul_acc #(.W(HALF_W)) u_acc (
    .clk     (clk),
    .rst     (rst),
    .step    (step),
    .pp      (pp),
    .a_q     (a_q),
    .b_q     (b_q),
    .product (product)
  );

  a_r6_accept_idle: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));
endmodule

// File: tb/test_seq_smul16.sv
module test_seq_smul16;
  localparam real CLK_NS = 4.0;

  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic        unsigned_mode;
  logic [15:0] op_a;
  logic [15:0] op_b;
  logic        busy;
  logic        done;
  logic [31:0] product;

  int errors = 0;
  int checks = 0;

  always #(CLK_NS / 2.0) clk = ~clk;

  seq_smul16 i_seq_smul16 (
    .clk           (clk),
    .rst           (rst),
    .start         (start),
    .unsigned_mode (unsigned_mode),
    .op_a          (op_a),
    .op_b          (op_b),
    .busy          (busy),
    .done          (done),
    .product       (product)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_mul(input logic [15:0] a, input logic [15:0] b,
                                          input bit um);
    logic signed [31:0] s;
    if (um) return {16'h0, a} * {16'h0, b};
    s = $signed(a) * $signed(b);
    return s;
  endfunction

  // Runs one operation; optionally scrambles inputs or re-pulses start while busy
  task automatic run_op(input logic [15:0] a, input logic [15:0] b, input bit um,
                        input bit scramble, input bit restart,
                        output logic [31:0] res, output int lat);
    int n = 0;
    @(negedge clk);
    op_a = a; op_b = b; unsigned_mode = um; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    forever begin
      if (scramble) begin
        op_a = 16'($urandom); op_b = 16'($urandom); unsigned_mode = ~um;
      end
      if (restart && n == 2) begin
        start = 1'b1; op_a = 16'h1234; op_b = 16'h0077;
      end else begin
        start = 1'b0;
      end
      @(posedge clk);
      n++;
      @(negedge clk);
      if (done || n > 40) break;
    end
    start = 1'b0;
    res = product;
    lat = n;
  endtask

  task automatic op_check(input logic [15:0] a, input logic [15:0] b, input bit um,
                          input string req);
    logic [31:0] r;
    int lat;
    run_op(a, b, um, 1'b0, 1'b0, r, lat);
    check(r == ref_mul(a, b, um), req, r, ref_mul(a, b, um));
    check(lat == (um ? 4 : 6), "R4 latency", 32'(lat), um ? 32'd4 : 32'd6);
  endtask

  task automatic t_reset();
    rst = 1'b1; start = 1'b0; unsigned_mode = 1'b0; op_a = '0; op_b = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!busy && !done && product == 32'h0, "R1 reset state",
          {busy, done, product[29:0]}, 32'h0);
    rst = 1'b0;
  endtask

  task automatic t_corners();
    op_check(16'h8000, 16'h8000, 1'b0, "R9 min*min");
    op_check(16'hFFFF, 16'hFFFF, 1'b0, "R9 -1*-1");
    op_check(16'h8000, 16'h0001, 1'b0, "R2 min*1");
    op_check(16'h0001, 16'h8000, 1'b0, "R2 1*min");
    op_check(16'h0000, 16'hBEEF, 1'b0, "R2 zero*x");
    op_check(16'h7FFF, 16'h7FFF, 1'b0, "R2 max*max");
    op_check(16'h7FFF, 16'h8000, 1'b0, "R2 max*min");
    op_check(16'hFFFF, 16'h00FF, 1'b0, "R2 -1*255");
  endtask

  task automatic t_unsigned();
    op_check(16'hFFFF, 16'hFFFF, 1'b1, "R3 unsigned ffff^2");
    op_check(16'h8000, 16'h8000, 1'b1, "R3 unsigned 8000^2");
    op_check(16'hABCD, 16'h00FF, 1'b1, "R3 unsigned mixed");
  endtask

  task automatic t_random();
    for (int i = 0; i < 40; i++) begin
      op_check(16'($urandom), 16'($urandom), 1'($urandom), "R2 R3 random");
    end
  endtask

  task automatic t_done_pulse();
    logic [31:0] r;
    int lat;
    run_op(16'hC000, 16'h0003, 1'b0, 1'b0, 1'b0, r, lat);
    check(!busy, "R5 busy low at done", {31'h0, busy}, 32'h0);
    @(negedge clk);
    check(!done, "R5 done one cycle", {31'h0, done}, 32'h0);
  endtask

  task automatic t_restart_ignored();
    logic [31:0] r;
    int lat;
    run_op(16'hF00D, 16'h8421, 1'b0, 1'b0, 1'b1, r, lat);
    check(r == ref_mul(16'hF00D, 16'h8421, 1'b0), "R6 start while busy result",
          r, ref_mul(16'hF00D, 16'h8421, 1'b0));
    check(lat == 6, "R6 start while busy latency", 32'(lat), 32'd6);
  endtask

  task automatic t_scramble();
    logic [31:0] r;
    int lat;
    run_op(16'h9ABC, 16'hDEF0, 1'b0, 1'b1, 1'b0, r, lat);
    check(r == ref_mul(16'h9ABC, 16'hDEF0, 1'b0), "R7 inputs changed signed",
          r, ref_mul(16'h9ABC, 16'hDEF0, 1'b0));
    run_op(16'hFFFE, 16'h8001, 1'b1, 1'b1, 1'b0, r, lat);
    check(r == ref_mul(16'hFFFE, 16'h8001, 1'b1), "R7 inputs changed unsigned",
          r, ref_mul(16'hFFFE, 16'h8001, 1'b1));
    check(lat == 4, "R7 mode latched", 32'(lat), 32'd4);
  endtask

  task automatic t_hold();
    logic [31:0] r;
    int lat;
    run_op(16'h8765, 16'h4321, 1'b0, 1'b0, 1'b0, r, lat);
    for (int i = 0; i < 5; i++) begin
      op_a = 16'($urandom); op_b = 16'($urandom);
      @(negedge clk);
    end
    check(product == r, "R8 product held", product, r);
  endtask

  initial begin
    #(CLK_NS * 150000);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    t_reset();
    t_corners();
    t_unsigned();
    t_done_pulse();
    t_restart_ignored();
    t_scramble();
    t_hold();
    t_random();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule